// File: doc/BRIEF.md
# Floating-Point Move Lane with Operand Bypass

This block is a three-stage lane (execute, memory access, write-back) for single-precision register moves, memory loads and stores, and the two sign-only operations: absolute value and negation. It holds its own register file of 32-bit entries. An operation is presented on the issue port during its decode cycle. The source operand is picked in that cycle, either from a bypass or from the register file, and is captured at the next rising edge.

The register file is written on the falling clock edge in the middle of the write-back cycle. An operation decoded in that same cycle already reads the new value, so the lane has no bypass from write-back. Bypasses come only from the execute stage, which holds move and sign results, and from the memory stage, which holds every result including load data. A load result reaches the memory stage first, so a consumer that depends on a load must be issued two or more cycles after it. Load data arrives on an input port in the load's memory-access cycle. Store data leaves on an output port in the store's execute cycle.

Top module: `fpls_lane`

## Requirements
- R1: After reset, `st_valid`, `fwd_ex_valid` and `fwd_ma_valid` are all low.
- R2: Opcode 0 (move) copies register `iss_src` into register `iss_dst`. One cycle after issue, `fwd_ex_valid` is high, `fwd_ex_idx` equals the destination and `fwd_ex_data` equals the source value.
- R3: Opcode 2 (store) drives `st_valid` high and puts the source value on `st_data` one cycle after issue. It writes no register, whatever `iss_dst` holds, and raises no execute bypass.
- R4: Opcode 3 (absolute value) writes the source value with bit 31 cleared. Bits 30..0 are unchanged, and the result appears on the execute bypass one cycle after issue.
- R5: Opcode 4 (negate) writes the source value with bit 31 inverted. Bits 30..0 are unchanged, and the result appears on the execute bypass one cycle after issue.
- R6: Opcode 1 (load) samples `ld_data` in the cycle two cycles after issue. In that same cycle it shows that value on `fwd_ma_data`, with `fwd_ma_valid` high and `fwd_ma_idx` equal to the destination. The value is then written to the destination.
- R7: An execute-stage result appears unchanged on the memory bypass one cycle later, with the same index.
- R8: A register written by a producer is read from the register file by a consumer issued exactly three cycles later, and the consumer gets the new value.
- R9: The source operand comes from the execute bypass if it matches, otherwise from the memory bypass if it matches, otherwise from the register file. A match needs the bypass valid bit and an index equal to `iss_src`. This gives correct results for consumers issued one or two cycles after their producer.
- R10: An issue with `iss_valid` low, or with opcode 5, 6 or 7, changes no register and raises no store or bypass output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pipeline registers on rising edge, register file on falling edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue port holds an operation this cycle |
| iss_op | input | 3 | Opcode: 0 move, 1 load, 2 store, 3 abs, 4 negate |
| iss_src | input | 4 | Source register index |
| iss_dst | input | 4 | Destination register index |
| ld_data | input | 32 | Load data, valid in the load's memory-access cycle |
| st_valid | output | 1 | Store in execute stage |
| st_data | output | 32 | Store data |
| fwd_ex_valid | output | 1 | Execute-stage bypass valid |
| fwd_ex_idx | output | 4 | Execute-stage bypass destination |
| fwd_ex_data | output | 32 | Execute-stage bypass value |
| fwd_ma_valid | output | 1 | Memory-stage bypass valid |
| fwd_ma_idx | output | 4 | Memory-stage bypass destination |
| fwd_ma_data | output | 32 | Memory-stage bypass value |

## Verification
Results arrive on fixed schedules after issue:
- Store data and execute-bypass results appear one rising edge after issue.
- The memory bypass follows one edge after that, or, for a load, shows `ld_data` in the cycle two edges after issue.
- A register becomes readable at the falling edge three cycles after issue.

The bench drives inputs and samples outputs two time units after each rising edge, so every registered output has settled. Register contents are read back through a store and checked one edge later. Dependent consumers are issued at distances of one, two, three and four cycles from their producer, so each operand source is exercised in turn.

// File: rtl/fpls_lane.sv
module fpls_lane #(
  parameter int DW   = 32,
  parameter int NREG = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic [2:0]    iss_op,
  input  logic [AW-1:0] iss_src,
  input  logic [AW-1:0] iss_dst,
  input  logic [DW-1:0] ld_data,
  output logic          st_valid,
  output logic [DW-1:0] st_data,
  output logic          fwd_ex_valid,
  output logic [AW-1:0] fwd_ex_idx,
  output logic [DW-1:0] fwd_ex_data,
  output logic          fwd_ma_valid,
  output logic [AW-1:0] fwd_ma_idx,
  output logic [DW-1:0] fwd_ma_data
);
  localparam logic [2:0] OP_MOV = 3'd0, OP_LD = 3'd1, OP_ST = 3'd2,
                         OP_ABS = 3'd3, OP_NEG = 3'd4;

  logic [DW-1:0] rf [NREG];

  logic          ex_valid;
  logic [2:0]    ex_op;
  logic [AW-1:0] ex_dst;
  logic [DW-1:0] ex_opnd;
  logic [DW-1:0] ex_res;
  logic          ex_wr;

  logic          ma_valid, ma_load;
  logic [AW-1:0] ma_dst;
  logic [DW-1:0] ma_data;

  logic          wb_valid;
  logic [AW-1:0] wb_dst;
  logic [DW-1:0] wb_data;

  logic          hit_ex, hit_ma;
  logic [DW-1:0] opnd;

  assign hit_ex = fwd_ex_valid && (fwd_ex_idx == iss_src);
  assign hit_ma = fwd_ma_valid && (fwd_ma_idx == iss_src);
  assign opnd   = hit_ex ? fwd_ex_data : hit_ma ? fwd_ma_data : rf[iss_src];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_valid <= 1'b0;
      ex_op    <= OP_MOV;
      ex_dst   <= '0;
      ex_opnd  <= '0;
    end else begin
      ex_valid <= iss_valid && (iss_op <= OP_NEG);
      ex_op    <= iss_op;
      ex_dst   <= iss_dst;
      ex_opnd  <= opnd;
    end
  end

  always_comb begin
    ex_res = ex_opnd;
    case (ex_op)
      OP_ABS:  ex_res = {1'b0, ex_opnd[DW-2:0]};
      OP_NEG:  ex_res = {~ex_opnd[DW-1], ex_opnd[DW-2:0]};
      default: ex_res = ex_opnd;
    endcase
  end

  assign ex_wr        = ex_valid && (ex_op != OP_ST);
  assign st_valid     = ex_valid && (ex_op == OP_ST);
  assign st_data      = ex_opnd;
  assign fwd_ex_valid = ex_wr && (ex_op != OP_LD);
  assign fwd_ex_idx   = ex_dst;
  assign fwd_ex_data  = ex_res;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ma_valid <= 1'b0;
      ma_load  <= 1'b0;
      ma_dst   <= '0;
      ma_data  <= '0;
    end else begin
      ma_valid <= ex_wr;
      ma_load  <= ex_op == OP_LD;
      ma_dst   <= ex_dst;
      ma_data  <= ex_res;
    end
  end

  assign fwd_ma_valid = ma_valid;
  assign fwd_ma_idx   = ma_dst;
  assign fwd_ma_data  = ma_load ? ld_data : ma_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_dst   <= '0;
      wb_data  <= '0;
    end else begin
      wb_valid <= ma_valid;
      wb_dst   <= ma_dst;
      wb_data  <= fwd_ma_data;
    end
  end

  always_ff @(negedge clk) begin
    if (wb_valid) rf[wb_dst] <= wb_data;
  end
endmodule

module fpls_lane_chk #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          iss_valid,
  input logic [2:0]    iss_op,
  input logic [AW-1:0] iss_dst,
  input logic [DW-1:0] ld_data,
  input logic          st_valid,
  input logic          fwd_ex_valid,
  input logic [AW-1:0] fwd_ex_idx,
  input logic [DW-1:0] fwd_ex_data,
  input logic          fwd_ma_valid,
  input logic [AW-1:0] fwd_ma_idx,
  input logic [DW-1:0] fwd_ma_data
);
  assert_store_nofwd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_op == 3'd2) |=> (st_valid && !fwd_ex_valid));

  assert_abs_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_op == 3'd3) |=>
      (fwd_ex_valid && !fwd_ex_data[DW-1] && fwd_ex_idx == $past(iss_dst)));

  assert_load_ma_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_op == 3'd1) |=> ##1 (fwd_ma_valid && fwd_ma_data == ld_data));

  assert_ex_to_ma_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_ex_valid |=> (fwd_ma_valid && fwd_ma_idx == $past(fwd_ex_idx)
                      && fwd_ma_data == $past(fwd_ex_data)));

  assert_unused_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_op > 3'd4) |=> (!fwd_ex_valid && !st_valid));
endmodule

bind fpls_lane fpls_lane_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/fpls_lane_tb.sv
module fpls_lane_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic [2:0]  iss_op = '0;
  logic [3:0]  iss_src = '0, iss_dst = '0;
  logic [31:0] ld_data = '0;
  logic        st_valid, fwd_ex_valid, fwd_ma_valid;
  logic [31:0] st_data, fwd_ex_data, fwd_ma_data;
  logic [3:0]  fwd_ex_idx, fwd_ma_idx;
  int errors = 0, checks = 0;

  fpls_lane u_dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); #2; endtask
  task automatic iss(input logic [2:0] op, input logic [3:0] s, input logic [3:0] d);
    iss_valid = 1'b1; iss_op = op; iss_src = s; iss_dst = d;
  endtask
  task automatic idle; iss_valid = 1'b0; endtask

  task automatic load_reg(input logic [3:0] r, input logic [31:0] v);
    iss(3'd1, 4'd0, r); tick; idle; tick; ld_data = v; tick; tick; tick;
  endtask

  task automatic read_reg(input string tag, input logic [3:0] r, input logic [31:0] exp);
    iss(3'd2, r, 4'd0); tick; idle;
    chk({tag, " st_valid"}, {31'd0, st_valid}, 32'd1);
    chk(tag, st_data, exp);
    tick; tick; tick;
  endtask

  task automatic t_reset;
    chk("R1 st_valid", {31'd0, st_valid}, 0);
    chk("R1 fwd_ex_valid", {31'd0, fwd_ex_valid}, 0);
    chk("R1 fwd_ma_valid", {31'd0, fwd_ma_valid}, 0);
  endtask

  task automatic t_move;
    load_reg(4'd1, 32'h3F80_0000);
    iss(3'd0, 4'd1, 4'd2); tick; idle;
    chk("R2 ex valid", {31'd0, fwd_ex_valid}, 1);
    chk("R2 ex idx", {28'd0, fwd_ex_idx}, 2);
    chk("R2 ex data", fwd_ex_data, 32'h3F80_0000);
    tick;
    chk("R7 ma valid", {31'd0, fwd_ma_valid}, 1);
    chk("R7 ma idx", {28'd0, fwd_ma_idx}, 2);
    chk("R7 ma data", fwd_ma_data, 32'h3F80_0000);
    tick; tick;
    read_reg("R3 readback r2", 4'd2, 32'h3F80_0000);
  endtask

  task automatic t_sign;
    load_reg(4'd3, 32'hC049_0FDB);
    iss(3'd3, 4'd3, 4'd4); tick;
    chk("R4 abs", fwd_ex_data, 32'h4049_0FDB);
    iss(3'd4, 4'd4, 4'd6); tick; idle;
    chk("R5 R9 neg of fwd abs", fwd_ex_data, 32'hC049_0FDB);
    iss(3'd4, 4'd3, 4'd5); tick; idle;
    chk("R5 neg", fwd_ex_data, 32'h4049_0FDB);
    tick; tick; tick;
    read_reg("R4 r4", 4'd4, 32'h4049_0FDB);
    read_reg("R5 r6", 4'd6, 32'hC049_0FDB);
  endtask

  task automatic t_distance(input int d);
    load_reg(4'd8, 32'h2222_2222);
    iss(3'd0, 4'd7, 4'd8); tick; idle;
    for (int i = 1; i < d; i++) tick;
    iss(3'd4, 4'd8, 4'd9); tick; idle;
    chk($sformatf("R8 R9 consumer at distance %0d", d), fwd_ex_data, 32'h9111_1111);
    tick; tick; tick;
  endtask

  task automatic t_priority;
    iss(3'd0, 4'd7, 4'd10); tick;
    iss(3'd4, 4'd7, 4'd10); tick;
    iss(3'd0, 4'd10, 4'd11); tick; idle;
    chk("R9 ex beats ma", fwd_ex_data, 32'h9111_1111);
    tick; tick; tick;
    read_reg("R9 last write wins r10", 4'd10, 32'h9111_1111);
  endtask

  task automatic t_load_fwd;
    iss(3'd1, 4'd0, 4'd12); tick; idle;
    chk("R6 load no ex fwd", {31'd0, fwd_ex_valid}, 0);
    tick; ld_data = 32'hDEAD_BEEF;
    iss(3'd0, 4'd12, 4'd13); #1;
    chk("R6 ma valid", {31'd0, fwd_ma_valid}, 1);
    chk("R6 ma idx", {28'd0, fwd_ma_idx}, 12);
    chk("R6 ma data", fwd_ma_data, 32'hDEAD_BEEF);
    tick; idle; ld_data = 32'h0;
    chk("R6 R9 consumer of load", fwd_ex_data, 32'hDEAD_BEEF);
    tick; tick; tick;
    read_reg("R6 r12", 4'd12, 32'hDEAD_BEEF);
  endtask

  task automatic t_ignored;
    iss(3'd0, 4'd7, 4'd2); iss_valid = 1'b0; tick;
    chk("R10 invalid no fwd", {31'd0, fwd_ex_valid}, 0);
    for (int op = 5; op < 8; op++) begin
      iss(op[2:0], 4'd7, 4'd2); tick; idle;
      chk($sformatf("R10 op %0d no fwd", op), {30'd0, fwd_ex_valid, st_valid}, 0);
    end
    iss(3'd2, 4'd7, 4'd2); tick; idle;
    chk("R3 store no ex fwd", {31'd0, fwd_ex_valid}, 0);
    tick; tick; tick;
    read_reg("R10 R3 r2 unchanged", 4'd2, 32'h3F80_0000);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run;
  end

  initial begin
    tick; tick; rst_n = 1'b1;
    t_reset;
    t_move;
    t_sign;
    load_reg(4'd7, 32'h1111_1111);
    for (int d = 1; d <= 4; d++) t_distance(d);
    t_priority;
    t_load_fwd;
    t_ignored;
    finish_run;
  end
endmodule